// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small microcontroller datapath. Each accepted operation takes a first operand, a second operand that is either a register value or an immediate, a 5-bit operation code and the current status flags. It returns a registered 8-bit result, a write-back strobe and an updated flag vector. Every operation touches only its own subset of the flags, and all other flags pass through unchanged. The sign-test flag is always rebuilt as N xor V.

A paired word mode adds an immediate to, or subtracts it from, a 16-bit register pair (high:low). It takes two clocks and reuses the single 8-bit adder: the low byte is handled in the first clock and the high byte, with the carry, in the second. While the second half is pending the unit raises `busy` and ignores new requests.

The flag vector is packed as bit 0 = C (carry/borrow), bit 1 = Z (zero), bit 2 = N (negative), bit 3 = V (two's-complement overflow), bit 4 = S (sign test), bit 5 = H (carry or borrow out of bit 3).

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid`, `busy`, `out_we`, `out_word` and `out_flags` all zero.
- R2: Op codes 0 (add), 1 (add with carry-in C), 2 (subtract), 3 (subtract with borrow-in C) and 6 (negate, 0 minus A) give their 8-bit result one clock after acceptance with `out_we`=1, and update C, Z, N, V and H: C is the carry out (add) or borrow out (subtract) of bit 7, H the same at bit 3, V the signed overflow.
- R3: For op codes 3 and 5, Z becomes 1 only when the result is zero and the incoming Z was 1.
- R4: Op codes 4 (compare) and 5 (compare with borrow-in) set the flags exactly as subtract and subtract-with-borrow would, but drive `out_we`=0.
- R5: Op codes 9 (A and B), 10 (A or B), 11 (A xor B), 12 (test: A), 13 (clear: 0), 14 (set bits: A or mask) and 15 (clear bits: A and not mask) update Z and N, clear V, and leave C and H unchanged.
- R6: Op codes 7 (A+1) and 8 (A-1) update Z, N and V (V set on 0x7F to 0x80 and 0x80 to 0x7F) and leave C and H unchanged.
- R7: Op code 16 (complement) returns 0xFF minus A, sets C to 1, clears V, updates Z and N and keeps H.
- R8: Op code 17 writes 0xFF and leaves C, Z, N, V and H unchanged; op codes 20 to 31 drive `out_we`=0 and leave the same flags unchanged.
- R9: Whenever `out_valid` is high, `out_flags` bit 4 equals bit 2 xor bit 3.
- R10: Op codes 18 (word add) and 19 (word subtract) treat `in_hi`:A as a 16-bit value and add or subtract B; `busy` is high for exactly one cycle, the result appears two clocks after acceptance on `out_hi`:`out_lo` with `out_word`=1 and `out_we`=1, and Z, C, N, V reflect the 16-bit result while H is unchanged.
- R11: A request presented while `busy` is high is ignored and does not change the pending word result.
- R12: When `in_use_imm` is 1, `in_imm` replaces `in_b` as the second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 5 | Operation code |
| in_use_imm | input | 1 | Select immediate as second operand |
| in_a | input | 8 | First operand (low byte in word mode) |
| in_b | input | 8 | Register second operand |
| in_imm | input | 8 | Immediate second operand |
| in_hi | input | 8 | High byte of the register pair in word mode |
| in_flags | input | 6 | Current status flags |
| busy | output | 1 | Word operation in progress |
| out_valid | output | 1 | Result registers hold a new result |
| out_we | output | 1 | Result should be written back |
| out_word | output | 1 | Result is a 16-bit pair |
| out_lo | output | 8 | Result, or low byte of a pair |
| out_hi | output | 8 | High byte of a pair result |
| out_flags | output | 6 | Updated status flags |

## Verification
The bench aims at the flag edges: 0x7F+1 and 0x80-1 for signed overflow, 0xFF+1 for carry, zero and half-carry together, and nibble borrows, where a wrong overflow or half-carry term would show a stale or inverted V or H. It drives subtract-with-borrow and compare-with-borrow with a zero result and the incoming Z both clear and set, which exposes a design that recomputes Z instead of keeping it sticky. Word operations at 0xFFFF+1 and 0x0000-1 check the carry from the low byte into the high byte and the two-clock timing, and a request pushed in during `busy` catches a unit that would accept it and corrupt the pending pair. Random flag inputs, including an inconsistent S, show any operation that disturbs a flag outside its own set or fails to rebuild S.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_NEG  = 5'd6,
    OP_INC  = 5'd7,
    OP_DEC  = 5'd8,
    OP_AND  = 5'd9,
    OP_OR   = 5'd10,
    OP_EOR  = 5'd11,
    OP_TST  = 5'd12,
    OP_CLR  = 5'd13,
    OP_SBM  = 5'd14,
    OP_CBM  = 5'd15,
    OP_COM  = 5'd16,
    OP_SER  = 5'd17,
    OP_WADD = 5'd18,
    OP_WSUB = 5'd19
  } alu_op_e;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
  localparam int NFLAG = 6;

  // masks: bit set = flag taken from the new value (S is always rebuilt)
  localparam logic [NFLAG-1:0] M_ARITH = 6'b101111;
  localparam logic [NFLAG-1:0] M_ZNV   = 6'b001110;
  localparam logic [NFLAG-1:0] M_ZNVC  = 6'b001111;
  localparam logic [NFLAG-1:0] M_NONE  = 6'b000000;

  function automatic logic [NFLAG-1:0] flag_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_CMP, OP_CPC, OP_NEG:            flag_mask = M_ARITH;
      OP_INC, OP_DEC, OP_AND, OP_OR,
      OP_EOR, OP_TST, OP_CLR, OP_SBM,
      OP_CBM:                            flag_mask = M_ZNV;
      OP_COM, OP_WADD, OP_WSUB:          flag_mask = M_ZNVC;
      default:                           flag_mask = M_NONE;
    endcase
  endfunction

  function automatic logic is_logic(alu_op_e op);
    case (op)
      OP_AND, OP_OR, OP_EOR, OP_TST, OP_CLR,
      OP_SBM, OP_CBM, OP_COM, OP_SER:    is_logic = 1'b1;
      default:                           is_logic = 1'b0;
    endcase
  endfunction

  function automatic logic writes_back(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC,
      OP_AND, OP_OR, OP_EOR, OP_TST, OP_CLR, OP_SBM, OP_CBM,
      OP_COM, OP_SER, OP_WADD, OP_WSUB:  writes_back = 1'b1;
      default:                           writes_back = 1'b0;
    endcase
  endfunction

  function automatic logic is_word(alu_op_e op);
    is_word = (op == OP_WADD) || (op == OP_WSUB);
  endfunction

  function automatic logic z_sticky(alu_op_e op);
    z_sticky = (op == OP_SBC) || (op == OP_CPC);
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          co,
  output logic          hc,
  output logic          ov
);
  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW:0] full;
  logic [HW:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
      low  = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      low  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, cin};
    end
    r  = full[DW-1:0];
    co = full[DW];
    hc = low[HW];
    if (sub) ov = (x[MSB] ^ y[MSB]) & (full[MSB] ^ x[MSB]);
    else     ov = ~(x[MSB] ^ y[MSB]) & (full[MSB] ^ x[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r
);
  always_comb begin
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_EOR:  r = a ^ b;
      OP_TST:  r = a;
      OP_CLR:  r = '0;
      OP_SBM:  r = a | b;
      OP_CBM:  r = a & ~b;
      OP_COM:  r = ~a;
      OP_SER:  r = '1;
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [NFLAG-1:0] old_f,
  input  logic [NFLAG-1:0] new_f,
  input  logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] out_f
);
  always_comb begin
    out_f     = (old_f & ~mask) | (new_f & mask);
    out_f[FS] = out_f[FN] ^ out_f[FV];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [4:0]       in_op,
  input  logic             in_use_imm,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  input  logic [DW-1:0]    in_imm,
  input  logic [DW-1:0]    in_hi,
  input  logic [NFLAG-1:0] in_flags,
  output logic             busy,
  output logic             out_valid,
  output logic             out_we,
  output logic             out_word,
  output logic [DW-1:0]    out_lo,
  output logic [DW-1:0]    out_hi,
  output logic [NFLAG-1:0] out_flags
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] ONE = DW'(1);

  typedef enum logic {ST_IDLE, ST_HIGH} state_e;

  state_e           state;
  logic [DW-1:0]    lo_q, hi_q;
  logic             cy_q, zlo_q, wsub_q;
  logic [NFLAG-1:0] flags_q;

  alu_op_e          op;
  logic [DW-1:0]    b_sel;
  logic             accept;

  logic [DW-1:0]    ax, ay, sum, lres, res;
  logic             acin, asub, co, hc, ov;
  logic [NFLAG-1:0] cand, old_f, mask, merged;

  assign op     = alu_op_e'(in_op);
  assign b_sel  = in_use_imm ? in_imm : in_b;
  assign busy   = (state == ST_HIGH);
  assign accept = in_valid & ~busy;

  // adder input selection; the high byte of a word op reuses the same adder
  always_comb begin
    ax = in_a; ay = b_sel; acin = 1'b0; asub = 1'b0;
    if (state == ST_HIGH) begin
      ax = hi_q; ay = '0; acin = cy_q; asub = wsub_q;
    end else begin
      case (op)
        OP_ADC:          acin = in_flags[FC];
        OP_SUB, OP_CMP,
        OP_WSUB:         asub = 1'b1;
        OP_SBC, OP_CPC:  begin asub = 1'b1; acin = in_flags[FC]; end
        OP_NEG:          begin ax = '0; ay = in_a; asub = 1'b1; end
        OP_INC:          ay = ONE;
        OP_DEC:          begin ay = ONE; asub = 1'b1; end
        default:         ;
      endcase
    end
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(ax), .y(ay), .cin(acin), .sub(asub),
    .r(sum), .co(co), .hc(hc), .ov(ov)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op), .a(in_a), .b(b_sel), .r(lres)
  );

  assign res = is_logic(op) ? lres : sum;

  // candidate flags, old flags and mask for the merge
  always_comb begin
    cand = '0;
    if (state == ST_HIGH) begin
      cand[FC] = co;
      cand[FZ] = zlo_q & (sum == '0);
      cand[FN] = sum[MSB];
      cand[FV] = ov;
      cand[FH] = hc;
      old_f    = flags_q;
      mask     = M_ZNVC;
    end else begin
      cand[FC] = (op == OP_COM) ? 1'b1 : co;
      cand[FZ] = (res == '0) & (z_sticky(op) ? in_flags[FZ] : 1'b1);
      cand[FN] = res[MSB];
      cand[FV] = is_logic(op) ? 1'b0 : ov;
      cand[FH] = hc;
      old_f    = in_flags;
      mask     = flag_mask(op);
    end
  end

  alu8_flags u_flags (
    .old_f(old_f), .new_f(cand), .mask(mask), .out_f(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      cy_q      <= 1'b0;
      zlo_q     <= 1'b0;
      wsub_q    <= 1'b0;
      flags_q   <= '0;
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_word  <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_flags <= '0;
    end else if (state == ST_HIGH) begin
      state     <= ST_IDLE;
      out_valid <= 1'b1;
      out_we    <= 1'b1;
      out_word  <= 1'b1;
      out_lo    <= lo_q;
      out_hi    <= sum;
      out_flags <= merged;
    end else if (accept && is_word(op)) begin
      state     <= ST_HIGH;
      lo_q      <= sum;
      hi_q      <= in_hi;
      cy_q      <= co;
      zlo_q     <= (sum == '0);
      wsub_q    <= (op == OP_WSUB);
      flags_q   <= in_flags;
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_word  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_we    <= writes_back(op);
      out_word  <= 1'b0;
      out_lo    <= res;
      out_hi    <= '0;
      out_flags <= merged;
    end else begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_word  <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !busy && !out_we && !out_word && out_flags == '0));

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_CMP || op == OP_CPC)) |=> (out_valid && !out_we));

  assert_logic_keeps_ch_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && is_logic(op) && op != OP_COM && op != OP_SER) |=>
      (out_flags[FC] == $past(in_flags[FC]) && out_flags[FH] == $past(in_flags[FH])
       && !out_flags[FV]));

  assert_com_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_COM) |=>
      (out_flags[FC] && !out_flags[FV] && out_lo == ~$past(in_a)));

  assert_ser_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SER) |=>
      (out_lo == '1 && out_flags[3:0] == $past(in_flags[3:0])
       && out_flags[FH] == $past(in_flags[FH])));

  assert_sign_flag_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags[FS] == (out_flags[FN] ^ out_flags[FV])));

  assert_word_two_clk_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && out_valid && out_word && out_we));

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid) |=> (out_word && !busy));

endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_use_imm;
  logic [4:0] in_op;
  logic [7:0] in_a, in_b, in_imm, in_hi;
  logic [5:0] in_flags;
  logic       busy, out_valid, out_we, out_word;
  logic [7:0] out_lo, out_hi;
  logic [5:0] out_flags;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  alu8_core #(.DW(8)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_use_imm(in_use_imm), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_hi(in_hi), .in_flags(in_flags), .busy(busy), .out_valid(out_valid),
    .out_we(out_we), .out_word(out_word), .out_lo(out_lo), .out_hi(out_hi),
    .out_flags(out_flags)
  );

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       we;
    logic       known;
    logic [5:0] fl;
  } exp_t;

  function automatic string req_of(int op);
    case (op)
      0, 1, 2, 6: return "R2";
      3: return "R3";
      4, 5: return "R4";
      7, 8: return "R6";
      9, 10, 11, 12, 13, 14, 15: return "R5";
      16: return "R7";
      18, 19: return "R10";
      default: return "R8";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(int op, int a, int b, int hi, logic [5:0] f);
    exp_t e;
    int r, x, y, cin, d;
    logic c, z, n, v, h, sub;
    c = f[0]; z = f[1]; n = f[2]; v = f[3]; h = f[5];
    e.we = 1'b1; e.hi = 8'h00; e.known = 1'b1; r = 0;
    x = a; y = b; cin = 0; sub = 1'b0;
    case (op)
      1: cin = int'(f[0]);
      2, 4: sub = 1'b1;
      3, 5: begin sub = 1'b1; cin = int'(f[0]); end
      6: begin x = 0; y = a; sub = 1'b1; end
      7: y = 1;
      8: begin y = 1; sub = 1'b1; end
      default: ;
    endcase
    if (op <= 8) begin
      if (sub) begin
        d = x - y - cin; r = d & 255;
        c = (d < 0) ? 1'b1 : 1'b0;
        if (op <= 6) h = (((x & 15) - (y & 15) - cin) < 0) ? 1'b1 : 1'b0;
        v = ((((x ^ y) & (x ^ r)) & 128) != 0) ? 1'b1 : 1'b0;
      end else begin
        d = x + y + cin; r = d & 255;
        c = (d > 255) ? 1'b1 : 1'b0;
        if (op <= 6) h = (((x & 15) + (y & 15) + cin) > 15) ? 1'b1 : 1'b0;
        v = ((((x ^ r) & (y ^ r)) & 128) != 0) ? 1'b1 : 1'b0;
      end
      if (op == 7 || op == 8) begin c = f[0]; end
      n = r[7];
      z = (r == 0) ? 1'b1 : 1'b0;
      if (op == 3 || op == 5) z = z & f[1];
      if (op == 4 || op == 5) e.we = 1'b0;
    end else if (op <= 16) begin
      case (op)
        9:  r = a & b;
        10: r = a | b;
        11: r = a ^ b;
        12: r = a;
        13: r = 0;
        14: r = a | b;
        15: r = a & (255 - b);
        default: begin r = 255 - a; c = 1'b1; end
      endcase
      v = 1'b0; n = r[7]; z = (r == 0) ? 1'b1 : 1'b0;
    end else if (op == 17) begin
      r = 255;
    end else if (op == 18 || op == 19) begin
      x = hi * 256 + a;
      if (op == 18) begin
        d = x + b; c = (d > 65535) ? 1'b1 : 1'b0; r = d & 65535;
        v = (hi < 128 && r >= 32768) ? 1'b1 : 1'b0;
      end else begin
        d = x - b; c = (d < 0) ? 1'b1 : 1'b0; r = d & 65535;
        v = (hi >= 128 && r < 32768) ? 1'b1 : 1'b0;
      end
      z = (r == 0) ? 1'b1 : 1'b0; n = r[15];
      e.hi = 8'(r >> 8);
    end else begin
      e.we = 1'b0; e.known = 1'b0;
    end
    e.lo = 8'(r);
    e.fl = {h, n ^ v, v, n, z, c};
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(int op, int a, int b, int imm, bit use_imm, int hi,
                        logic [5:0] f, bit poke_busy);
    exp_t e;
    string rq;
    rq = req_of(op);
    e = model(op, a, use_imm ? imm : b, hi, f);
    @(negedge clk);
    in_valid = 1'b1; in_op = 5'(op); in_a = 8'(a); in_b = 8'(b);
    in_imm = 8'(imm); in_use_imm = use_imm; in_hi = 8'(hi); in_flags = f;
    if (op == 18 || op == 19) begin
      @(negedge clk);
      check(busy == 1'b1 && out_valid == 1'b0, "R10", "busy phase", {busy, out_valid}, 2);
      if (poke_busy) begin
        in_op = 5'd17; in_a = 8'h00; in_flags = 6'h00; in_hi = 8'h00;
      end else in_valid = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      check(busy == 1'b0 && out_valid && out_word && out_we,
            poke_busy ? "R11" : "R10", "word strobes", {busy, out_valid, out_word, out_we}, 7);
      check({out_hi, out_lo} == {e.hi, e.lo}, poke_busy ? "R11" : "R10", "word result",
            {out_hi, out_lo}, {e.hi, e.lo});
      check(out_flags == e.fl, "R10", "word flags", out_flags, e.fl);
    end else begin
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, rq, "valid", out_valid, 1);
      check(out_we == e.we, rq, "write enable", out_we, e.we);
      if (e.known) check(out_lo == e.lo, use_imm ? "R12" : rq, "result", out_lo, e.lo);
      check(out_flags == e.fl, rq, "flags", out_flags, e.fl);
    end
    check(out_flags[4] == (out_flags[2] ^ out_flags[3]), "R9", "sign flag",
          out_flags[4], out_flags[2] ^ out_flags[3]);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_a1b0));
    rst = 1'b1; in_valid = 1'b0; in_op = 5'd0; in_use_imm = 1'b0;
    in_a = 8'h00; in_b = 8'h00; in_imm = 8'h00; in_hi = 8'h00; in_flags = 6'h00;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && busy == 1'b0 && out_we == 1'b0 && out_flags == 6'h00,
          "R1", "reset state", {out_valid, busy, out_we, out_flags}, 0);
    rst = 1'b0;

    // directed corners
    run_op(0, 8'h7F, 8'h01, 0, 0, 0, 6'h00, 0);   // R2 signed overflow, half carry
    run_op(0, 8'hFF, 8'h01, 0, 0, 0, 6'h00, 0);   // R2 carry, zero
    run_op(1, 8'h0F, 8'h00, 0, 0, 0, 6'h01, 0);   // R2 carry-in into nibble
    run_op(2, 8'h80, 8'h01, 0, 0, 0, 6'h00, 0);   // R2 overflow on subtract
    run_op(2, 8'h10, 8'h01, 0, 0, 0, 6'h00, 0);   // R2 half borrow
    run_op(6, 8'h80, 0, 0, 0, 0, 6'h00, 0);       // R2 negate most negative
    run_op(6, 8'h00, 0, 0, 0, 0, 6'h3F, 0);       // R2 negate zero
    run_op(3, 8'h05, 8'h05, 0, 0, 0, 6'h00, 0);   // R3 zero result, Z in clear
    run_op(3, 8'h05, 8'h05, 0, 0, 0, 6'h02, 0);   // R3 zero result, Z in set
    run_op(5, 8'h05, 8'h04, 0, 0, 0, 6'h03, 0);   // R3 borrow-in makes zero
    run_op(4, 8'h30, 8'h40, 0, 0, 0, 6'h00, 0);   // R4 compare
    run_op(4, 8'h30, 8'h00, 8'h30, 1, 0, 6'h00, 0); // R4 R12 compare immediate
    run_op(10, 8'h0F, 8'hFF, 8'hF0, 1, 0, 6'h21, 0); // R12 immediate selected
    run_op(15, 8'hFF, 8'h00, 8'h0F, 1, 0, 6'h21, 0); // R5 clear bits
    run_op(14, 8'h00, 8'h00, 8'h80, 1, 0, 6'h08, 0); // R5 set bits, V cleared
    run_op(13, 8'h55, 8'h00, 0, 0, 0, 6'h2F, 0);  // R5 clear
    run_op(7, 8'h7F, 0, 0, 0, 0, 6'h21, 0);       // R6 increment overflow
    run_op(8, 8'h80, 0, 0, 0, 0, 6'h00, 0);       // R6 decrement overflow
    run_op(16, 8'h00, 0, 0, 0, 0, 6'h20, 0);      // R7 complement
    run_op(16, 8'hFF, 0, 0, 0, 0, 6'h08, 0);      // R7 complement to zero
    run_op(17, 8'h12, 0, 0, 0, 0, 6'h2F, 0);      // R8 set register, S rebuilt
    run_op(31, 8'h12, 8'h34, 0, 0, 0, 6'h25, 0);  // R8 unused code
    run_op(18, 8'hFF, 8'h01, 0, 0, 8'hFF, 6'h20, 0); // R10 0xFFFF+1
    run_op(19, 8'h00, 8'h01, 0, 0, 8'h00, 6'h00, 1); // R10 R11 0x0000-1
    run_op(19, 8'h00, 8'h01, 0, 0, 8'h80, 6'h00, 1); // R10 R11 0x8000-1
    run_op(18, 8'hF0, 8'h3F, 0, 0, 8'h7F, 6'h00, 0); // R10 carry into 0x8000

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 20));
      if (op == 20) op = int'($urandom_range(20, 31));
      run_op(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
             int'($urandom_range(0, 255)), 6'($urandom_range(0, 63)),
             1'($urandom_range(0, 1)));
    end

    @(negedge clk);
    check(out_valid == 1'b0, "R11", "no result after idle", out_valid, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule